// File: doc/BRIEF.md
# In-Order Retirement Buffer with Entry Status

This block is the in-order backbone of an out-of-order core. Instructions arrive in program order and each one takes the next slot of a circular table. The block returns the slot index to the issuing logic, so execution can report progress by that index. Each slot holds a small status code, up to four destination register numbers, and an optional memory write (address and size).

Retirement works from the oldest slot onward. Up to eight consecutive oldest slots can leave in one cycle, and only once they have finished executing. A slot that carries a memory write leaves only while the downstream load/store queue still reports room, and it hands its address and size to that queue as it leaves. The block also keeps a rename table that maps each architectural register to the slot that will produce it. Retirement clears a mapping that still points at the retiring slot.

An empty table is marked by a sentinel value in both the allocation pointer and the retirement pointer.

Top module: `rob_top`

## Requirements
- R1: After reset the block is empty. Both pointers read the sentinel value 192, `robFull` is low, every slot reads status 7 (invalid), and no register mapping is pending.
- R2: Allocation into an empty table begins at index 0 and sets both pointers to 0. Later allocations take consecutive indices and wrap from 191 to 0. Lanes are granted only as a contiguous run that starts at lane 0, so a request on lane i is granted only if lanes 0..i-1 are also granted.
- R3: A newly allocated slot reads status 0 (issued). A dispatch update sets status 1, and a completion update sets status 2. When a slot gets both updates in the same cycle, the completion wins.
- R4: Dispatch or completion updates aimed at an index that is not currently allocated leave its status unchanged. This includes slots that have already retired.
- R5: Only the slot at the retirement pointer, and the run of slots directly after it, may retire, and each one only when its status is 2. At most 8 slots retire per cycle. Retirement stops at the first slot that is not eligible. `retValid` is asserted combinationally in the cycle after the completion is registered, and the retired slot then reads status 3.
- R6: When the slot at the allocation pointer retires and nothing is allocated in the same cycle, both pointers return to the sentinel value 192.
- R7: With all 192 slots occupied, `robFull` is high and no lane is granted. When fewer slots are free than lanes requested, only as many leading lanes are granted as there are free slots. A slot freed in a cycle can be allocated from the next cycle onward.
- R8: A slot with a nonzero write address retires only while the number of such slots retiring in the same cycle does not exceed `lsqFree`. A retiring write drives `stValid` on its lane, together with its address and size.
- R9: Allocation maps each enabled destination register to the new slot index, and a later lane overrides an earlier one. Retirement clears a register's pending mapping only if the mapping still names the retiring index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| allocValid | input | 8 | Per-lane allocation request |
| allocDstEn | input | 8x4 | Per-lane destination register enables |
| allocDstReg | input | 8x4x6 | Per-lane destination register numbers |
| allocStAddr | input | 8x32 | Per-lane memory write address, 0 means no write |
| allocStSize | input | 8x4 | Per-lane memory write size |
| allocGrant | output | 8 | Per-lane allocation accepted |
| allocIdx | output | 8x8 | Slot index offered to each lane |
| robFull | output | 1 | All slots occupied |
| dspValid | input | 2 | Dispatch update strobes |
| dspIdx | input | 2x8 | Dispatch update indices |
| cplValid | input | 2 | Completion update strobes |
| cplIdx | input | 2x8 | Completion update indices |
| lsqFree | input | 7 | Free entries in the load/store queue |
| retValid | output | 8 | Per-lane retirement this cycle |
| retIdx | output | 8x8 | Index retiring on each lane |
| stValid | output | 8 | Retiring lane hands a write to the load/store queue |
| stAddr | output | 8x32 | Write address per retiring lane |
| stSize | output | 8x4 | Write size per retiring lane |
| aliasReg | input | 6 | Register number to look up in the rename table |
| aliasPending | output | 1 | Looked-up register awaits an in-flight slot |
| aliasIdx | output | 8 | Producing slot of the looked-up register |
| peekIdx | input | 8 | Slot index to inspect |
| peekStatus | output | 3 | Status of the inspected slot |
| issuePtr | output | 8 | Allocation pointer, 192 when empty |
| commitPtr | output | 8 | Retirement pointer, 192 when empty |
| robEmpty | output | 1 | Table is empty |

## Verification
Allocation is driven with a three-lane burst, a request pattern with a gap (lane 0 and lane 2 only), and full-width bursts that fill the table and then wrap. Together these separate contiguous granting from per-lane granting and show where a saturating free count takes effect. Completion is driven in order, out of order with the oldest slot held back, and against unallocated or already-retired indices. These patterns tell a correct oldest-first, eight-wide stop-at-first-blocked retirement apart from one that skips holes or accepts stale updates. Memory write slots are retired under zero, one and two free load/store queue entries, which shows in-order gating of writes. Two slots that name the same destination show that retirement clears a rename mapping only while it is still current.

// File: rtl/rob_pkg.sv
package rob_pkg;
  parameter int ROB_DEPTH = 192;
  parameter int ISSUE_W   = 8;
  parameter int COMMIT_W  = 8;
  parameter int DSP_W     = 2;
  parameter int CPL_W     = 2;
  parameter int NUM_DST   = 4;
  parameter int NUM_REGS  = 64;
  parameter int ADDR_W    = 32;
  parameter int SIZE_W    = 4;
  parameter int LSQ_CNT_W = 7;

  localparam int IDX_W = $clog2(ROB_DEPTH);
  localparam int PTR_W = $clog2(ROB_DEPTH + 1);
  localparam int REG_W = $clog2(NUM_REGS);
  localparam logic [PTR_W-1:0] PTR_NONE = PTR_W'(ROB_DEPTH);

  typedef enum logic [2:0] {
    ST_ISSUED = 3'd0,
    ST_DISP   = 3'd1,
    ST_EXEC   = 3'd2,
    ST_DONE   = 3'd3,
    ST_FREE   = 3'd7
  } status_e;

  typedef struct packed {
    logic [2:0]                       stat;
    logic [NUM_DST-1:0]               dstEn;
    logic [NUM_DST-1:0][REG_W-1:0]    dstReg;
    logic [ADDR_W-1:0]                stAddr;
    logic [SIZE_W-1:0]                stSize;
  } entry_t;

  typedef struct packed {
    logic             pend;
    logic [IDX_W-1:0] idx;
  } alias_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [ISSUE_W-1:0]             allocEn;
    logic [ISSUE_W-1:0][IDX_W-1:0]  allocIdx;
    logic [COMMIT_W-1:0]            retEn;
    logic [DSP_W-1:0]               dspEn;
    logic [CPL_W-1:0]               cplEn;
  } strobe_t;

  function automatic logic [IDX_W-1:0] wrapAdd(input logic [IDX_W-1:0] a, input int b);
    int s;
    s = int'(a) + b;
    while (s >= ROB_DEPTH) s = s - ROB_DEPTH;
    return IDX_W'(s);
  endfunction
endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [ISSUE_W-1:0]              allocValid,
  input  logic [DSP_W-1:0]                dspValid,
  input  logic [DSP_W-1:0][IDX_W-1:0]     dspIdx,
  input  logic [CPL_W-1:0]                cplValid,
  input  logic [CPL_W-1:0][IDX_W-1:0]     cplIdx,
  input  logic [LSQ_CNT_W-1:0]            lsqFree,
  input  logic [COMMIT_W-1:0][2:0]        headStat,
  input  logic [COMMIT_W-1:0]             headHasSt,
  output logic [COMMIT_W-1:0][IDX_W-1:0]  headIdx,
  output strobe_t                         strb,
  output logic                            robFull,
  output logic                            robEmpty,
  output logic [PTR_W-1:0]                issuePtr,
  output logic [PTR_W-1:0]                commitPtr
);
  logic [PTR_W-1:0] issueQ, commitQ, issueN, commitN;
  logic [IDX_W-1:0] issueLo, commitLo, allocBase, lastIdx;
  logic [ISSUE_W-1:0]            allocEnC;
  logic [ISSUE_W-1:0][IDX_W-1:0] allocIdxC;
  logic [COMMIT_W-1:0]           retEnC;
  logic [DSP_W-1:0]              dspEnC;
  logic [CPL_W-1:0]              cplEnC;
  int used, freeCnt, nAlloc, nRet, stores, usedNext;

  assign issueLo  = issueQ[IDX_W-1:0];
  assign commitLo = commitQ[IDX_W-1:0];
  assign robEmpty = (issueQ == PTR_NONE);

  always_comb begin : occupancy
    if (robEmpty) begin
      used = 0;
    end else begin
      used = int'(issueLo) - int'(commitLo);
      if (used < 0) used = used + ROB_DEPTH;
      used = used + 1;
    end
    freeCnt = ROB_DEPTH - used;
  end

  assign robFull = (used == ROB_DEPTH);

  function automatic logic isLive(input logic [IDX_W-1:0] idx, input int occ,
                                  input logic [IDX_W-1:0] head);
    int off;
    off = int'(idx) - int'(head);
    if (off < 0) off = off + ROB_DEPTH;
    return (int'(idx) < ROB_DEPTH) && (off < occ);
  endfunction

  always_comb begin : allocPick
    allocBase = robEmpty ? '0 : wrapAdd(issueLo, 1);
    nAlloc    = 0;
    lastIdx   = issueLo;
    allocEnC  = '0;
    for (int i = 0; i < ISSUE_W; i++) begin
      allocIdxC[i] = wrapAdd(allocBase, i);
      if (allocValid[i] && (nAlloc == i) && (i < freeCnt)) begin
        allocEnC[i] = 1'b1;
        nAlloc      = nAlloc + 1;
        lastIdx     = allocIdxC[i];
      end
    end
  end

  always_comb begin : retirePick
    nRet   = 0;
    stores = 0;
    retEnC = '0;
    for (int j = 0; j < COMMIT_W; j++) begin
      headIdx[j] = wrapAdd(commitLo, j);
      if ((nRet == j) && (j < used) && (headStat[j] == ST_EXEC) &&
          (!headHasSt[j] || (stores < int'(lsqFree)))) begin
        retEnC[j] = 1'b1;
        nRet      = nRet + 1;
        if (headHasSt[j]) stores = stores + 1;
      end
    end
  end

  always_comb begin : updateFilter
    for (int k = 0; k < DSP_W; k++)
      dspEnC[k] = dspValid[k] && isLive(dspIdx[k], used, commitLo);
    for (int k = 0; k < CPL_W; k++)
      cplEnC[k] = cplValid[k] && isLive(cplIdx[k], used, commitLo);
  end

  always_comb begin : nextPtr
    usedNext = used - nRet + nAlloc;
    if (usedNext == 0) begin
      issueN  = PTR_NONE;
      commitN = PTR_NONE;
    end else begin
      commitN = robEmpty ? '0 : PTR_W'(wrapAdd(commitLo, nRet));
      issueN  = (nAlloc > 0) ? PTR_W'(lastIdx) : issueQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      issueQ  <= PTR_NONE;
      commitQ <= PTR_NONE;
    end else begin
      issueQ  <= issueN;
      commitQ <= commitN;
    end
  end

  assign strb = '{allocEn: allocEnC, allocIdx: allocIdxC, retEn: retEnC,
                  dspEn: dspEnC, cplEn: cplEnC};
  assign issuePtr  = issueQ;
  assign commitPtr = commitQ;
endmodule

// File: rtl/rob_store.sv
module rob_store
  import rob_pkg::*;
(
  input  logic                                     clk,
  input  logic                                     rstN,
  input  strobe_t                                  strb,
  input  logic [ISSUE_W-1:0][NUM_DST-1:0]          allocDstEn,
  input  logic [ISSUE_W-1:0][NUM_DST-1:0][REG_W-1:0] allocDstReg,
  input  logic [ISSUE_W-1:0][ADDR_W-1:0]           allocStAddr,
  input  logic [ISSUE_W-1:0][SIZE_W-1:0]           allocStSize,
  input  logic [DSP_W-1:0][IDX_W-1:0]              dspIdx,
  input  logic [CPL_W-1:0][IDX_W-1:0]              cplIdx,
  input  logic [COMMIT_W-1:0][IDX_W-1:0]           headIdx,
  input  logic [REG_W-1:0]                         aliasReg,
  input  logic [IDX_W-1:0]                         peekIdx,
  output logic [COMMIT_W-1:0][2:0]                 headStat,
  output logic [COMMIT_W-1:0]                      headHasSt,
  output logic [COMMIT_W-1:0]                      stValid,
  output logic [COMMIT_W-1:0][ADDR_W-1:0]          stAddr,
  output logic [COMMIT_W-1:0][SIZE_W-1:0]          stSize,
  output logic                                     aliasPending,
  output logic [IDX_W-1:0]                         aliasIdx,
  output logic [2:0]                               peekStatus
);
  entry_t ent [ROB_DEPTH];
  alias_t rat [NUM_REGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < ROB_DEPTH; e++)
        ent[e] <= '{stat: ST_FREE, dstEn: '0, dstReg: '0, stAddr: '0, stSize: '0};
    end else begin
      for (int i = 0; i < ISSUE_W; i++)
        if (strb.allocEn[i])
          ent[strb.allocIdx[i]] <= '{stat: ST_ISSUED, dstEn: allocDstEn[i],
                                     dstReg: allocDstReg[i], stAddr: allocStAddr[i],
                                     stSize: allocStSize[i]};
      for (int k = 0; k < DSP_W; k++)
        if (strb.dspEn[k]) ent[dspIdx[k]].stat <= ST_DISP;
      for (int k = 0; k < CPL_W; k++)
        if (strb.cplEn[k]) ent[cplIdx[k]].stat <= ST_EXEC;
      for (int j = 0; j < COMMIT_W; j++)
        if (strb.retEn[j]) ent[headIdx[j]].stat <= ST_DONE;
    end
  end

  // rename table: retire clears through the retiring slot's own destinations,
  // then younger allocations override in lane order
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGS; r++) rat[r] <= '0;
    end else begin
      for (int j = 0; j < COMMIT_W; j++)
        for (int d = 0; d < NUM_DST; d++)
          if (strb.retEn[j] && ent[headIdx[j]].dstEn[d] &&
              rat[ent[headIdx[j]].dstReg[d]].pend &&
              (rat[ent[headIdx[j]].dstReg[d]].idx == headIdx[j]))
            rat[ent[headIdx[j]].dstReg[d]].pend <= 1'b0;
      for (int i = 0; i < ISSUE_W; i++)
        for (int d = 0; d < NUM_DST; d++)
          if (strb.allocEn[i] && allocDstEn[i][d])
            rat[allocDstReg[i][d]] <= '{pend: 1'b1, idx: strb.allocIdx[i]};
    end
  end

  for (genvar g = 0; g < COMMIT_W; g++) begin : gHead
    logic inRange;
    assign inRange      = (int'(headIdx[g]) < ROB_DEPTH);
    assign headStat[g]  = inRange ? ent[headIdx[g]].stat : ST_FREE;
    assign headHasSt[g] = inRange && (ent[headIdx[g]].stAddr != '0);
    assign stValid[g]   = strb.retEn[g] && headHasSt[g];
    assign stAddr[g]    = inRange ? ent[headIdx[g]].stAddr : '0;
    assign stSize[g]    = inRange ? ent[headIdx[g]].stSize : '0;
  end

  assign aliasPending = rat[aliasReg].pend;
  assign aliasIdx     = rat[aliasReg].idx;
  assign peekStatus   = (int'(peekIdx) < ROB_DEPTH) ? ent[peekIdx].stat : ST_FREE;
endmodule

// File: rtl/rob_top.sv
module rob_top
  import rob_pkg::*;
(
  input  logic                                       clk,
  input  logic                                       rstN,
  input  logic [ISSUE_W-1:0]                         allocValid,
  input  logic [ISSUE_W-1:0][NUM_DST-1:0]            allocDstEn,
  input  logic [ISSUE_W-1:0][NUM_DST-1:0][REG_W-1:0] allocDstReg,
  input  logic [ISSUE_W-1:0][ADDR_W-1:0]             allocStAddr,
  input  logic [ISSUE_W-1:0][SIZE_W-1:0]             allocStSize,
  output logic [ISSUE_W-1:0]                         allocGrant,
  output logic [ISSUE_W-1:0][IDX_W-1:0]              allocIdx,
  output logic                                       robFull,
  input  logic [DSP_W-1:0]                           dspValid,
  input  logic [DSP_W-1:0][IDX_W-1:0]                dspIdx,
  input  logic [CPL_W-1:0]                           cplValid,
  input  logic [CPL_W-1:0][IDX_W-1:0]                cplIdx,
  input  logic [LSQ_CNT_W-1:0]                       lsqFree,
  output logic [COMMIT_W-1:0]                        retValid,
  output logic [COMMIT_W-1:0][IDX_W-1:0]             retIdx,
  output logic [COMMIT_W-1:0]                        stValid,
  output logic [COMMIT_W-1:0][ADDR_W-1:0]            stAddr,
  output logic [COMMIT_W-1:0][SIZE_W-1:0]            stSize,
  input  logic [REG_W-1:0]                           aliasReg,
  output logic                                       aliasPending,
  output logic [IDX_W-1:0]                           aliasIdx,
  input  logic [IDX_W-1:0]                           peekIdx,
  output logic [2:0]                                 peekStatus,
  output logic [PTR_W-1:0]                           issuePtr,
  output logic [PTR_W-1:0]                           commitPtr,
  output logic                                       robEmpty
);
  strobe_t                        strb;
  logic [COMMIT_W-1:0][IDX_W-1:0] headIdx;
  logic [COMMIT_W-1:0][2:0]       headStat;
  logic [COMMIT_W-1:0]            headHasSt;

  rob_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .allocValid(allocValid),
    .dspValid(dspValid), .dspIdx(dspIdx), .cplValid(cplValid), .cplIdx(cplIdx),
    .lsqFree(lsqFree), .headStat(headStat), .headHasSt(headHasSt),
    .headIdx(headIdx), .strb(strb), .robFull(robFull), .robEmpty(robEmpty),
    .issuePtr(issuePtr), .commitPtr(commitPtr)
  );

  rob_store u_store (
    .clk(clk), .rstN(rstN), .strb(strb),
    .allocDstEn(allocDstEn), .allocDstReg(allocDstReg),
    .allocStAddr(allocStAddr), .allocStSize(allocStSize),
    .dspIdx(dspIdx), .cplIdx(cplIdx), .headIdx(headIdx),
    .aliasReg(aliasReg), .peekIdx(peekIdx),
    .headStat(headStat), .headHasSt(headHasSt),
    .stValid(stValid), .stAddr(stAddr), .stSize(stSize),
    .aliasPending(aliasPending), .aliasIdx(aliasIdx), .peekStatus(peekStatus)
  );

  assign allocGrant = strb.allocEn;
  assign allocIdx   = strb.allocIdx;
  assign retValid   = strb.retEn;
  assign retIdx     = headIdx;
endmodule

// File: rtl/rob_chk.sv
module rob_chk
  import rob_pkg::*;
(
  input logic                            clk,
  input logic                            rstN,
  input logic [ISSUE_W-1:0]              allocValid,
  input logic [ISSUE_W-1:0]              allocGrant,
  input logic                            robFull,
  input logic                            robEmpty,
  input logic [PTR_W-1:0]                issuePtr,
  input logic [PTR_W-1:0]                commitPtr,
  input logic [COMMIT_W-1:0]             retValid,
  input logic [COMMIT_W-1:0][IDX_W-1:0]  retIdx,
  input logic [COMMIT_W-1:0]             stValid,
  input logic [LSQ_CNT_W-1:0]            lsqFree
);
  logic drainAll;
  always_comb begin
    drainAll = 1'b0;
    for (int j = 0; j < COMMIT_W; j++)
      if (retValid[j] && (retIdx[j] == issuePtr[IDX_W-1:0])) drainAll = 1'b1;
  end

  // R1
  empty_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    robEmpty |-> (commitPtr == PTR_NONE));

  // R2
  grant_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((allocGrant & ~allocValid) == '0) && ((allocGrant & (allocGrant + ISSUE_W'(1))) == '0));

  // R2
  first_alloc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (robEmpty && allocGrant[0]) |=> (commitPtr == '0) && !robEmpty);

  // R5
  ret_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retValid & (retValid + COMMIT_W'(1))) == '0);

  // R5
  head_ret_chk: assert property (@(posedge clk) disable iff (!rstN)
    retValid[0] |-> (retIdx[0] == commitPtr[IDX_W-1:0]));

  // R6
  drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (drainAll && (allocGrant == '0)) |=> robEmpty && (issuePtr == PTR_NONE));

  // R7
  full_blk_chk: assert property (@(posedge clk) disable iff (!rstN)
    robFull |-> (allocGrant == '0));

  // R8
  lsq_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((stValid & ~retValid) == '0) && ($countones(stValid) <= int'(lsqFree)));
endmodule

bind rob_top rob_chk u_chk (.*);

// File: tb/rob_top_test.sv
module rob_top_test;
  import rob_pkg::*;
  localparam int CLK_P = 10;

  logic clk = 0, rstN = 0;
  logic [ISSUE_W-1:0]                         allocValid;
  logic [ISSUE_W-1:0][NUM_DST-1:0]            allocDstEn;
  logic [ISSUE_W-1:0][NUM_DST-1:0][REG_W-1:0] allocDstReg;
  logic [ISSUE_W-1:0][ADDR_W-1:0]             allocStAddr;
  logic [ISSUE_W-1:0][SIZE_W-1:0]             allocStSize;
  logic [ISSUE_W-1:0]                         allocGrant;
  logic [ISSUE_W-1:0][IDX_W-1:0]              allocIdx;
  logic                                       robFull, robEmpty, aliasPending;
  logic [DSP_W-1:0]                           dspValid;
  logic [DSP_W-1:0][IDX_W-1:0]                dspIdx;
  logic [CPL_W-1:0]                           cplValid;
  logic [CPL_W-1:0][IDX_W-1:0]                cplIdx;
  logic [LSQ_CNT_W-1:0]                       lsqFree;
  logic [COMMIT_W-1:0]                        retValid, stValid;
  logic [COMMIT_W-1:0][IDX_W-1:0]             retIdx;
  logic [COMMIT_W-1:0][ADDR_W-1:0]            stAddr;
  logic [COMMIT_W-1:0][SIZE_W-1:0]            stSize;
  logic [REG_W-1:0]                           aliasReg;
  logic [IDX_W-1:0]                           aliasIdx, peekIdx;
  logic [2:0]                                 peekStatus;
  logic [PTR_W-1:0]                           issuePtr, commitPtr;

  int nChk = 0, nBad = 0;
  bit finished = 0;

  rob_top uut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clearIn();
    allocValid = '0; allocDstEn = '0; allocDstReg = '0; allocStAddr = '0; allocStSize = '0;
    dspValid = '0; dspIdx = '0; cplValid = '0; cplIdx = '0; lsqFree = '0;
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    clearIn();
  endtask

  task automatic peekChk(input string req, input int idx, input int exp);
    peekIdx = IDX_W'(idx); #1;
    chk(req, 64'(peekStatus), 64'(exp));
  endtask

  task automatic aliasChk(input string req, input int r, input logic expPend, input int expIdx);
    aliasReg = REG_W'(r); #1;
    chk(req, 64'(aliasPending), 64'(expPend));
    if (expPend) chk(req, 64'(aliasIdx), 64'(expIdx));
  endtask

  task automatic doReset();
    clearIn(); aliasReg = '0; peekIdx = '0;
    rstN = 0;
    repeat (2) @(posedge clk);
    #1 rstN = 1;
  endtask

  task automatic testReset();
    doReset();
    #1;
    chk("R1 empty", 64'(robEmpty), 1);
    chk("R1 issuePtr", 64'(issuePtr), ROB_DEPTH);
    chk("R1 commitPtr", 64'(commitPtr), ROB_DEPTH);
    chk("R1 full", 64'(robFull), 0);
    peekChk("R1 status0", 0, 7);
    peekChk("R1 status191", 191, 7);
    aliasChk("R1 alias", 3, 1'b0, 0);
  endtask

  task automatic testAllocStatus();
    doReset();
    allocValid = 8'b0000_0111;
    allocDstEn[1][0] = 1'b1; allocDstReg[1][0] = 6'd5;
    allocDstEn[2][1] = 1'b1; allocDstReg[2][1] = 6'd5;
    #1;
    chk("R2 grant", 64'(allocGrant), 8'b0000_0111);
    chk("R2 idx0", 64'(allocIdx[0]), 0);
    chk("R2 idx2", 64'(allocIdx[2]), 2);
    cyc();
    chk("R2 commitPtr", 64'(commitPtr), 0);
    chk("R2 issuePtr", 64'(issuePtr), 2);
    peekChk("R3 issued", 1, 0);
    aliasChk("R9 later lane wins", 5, 1'b1, 2);
    dspValid = 2'b11; dspIdx[0] = 8'd1; dspIdx[1] = 8'd0;
    cplValid = 2'b11; cplIdx[0] = 8'd0; cplIdx[1] = 8'd50;
    cyc();
    peekChk("R3 dispatched", 1, 1);
    peekChk("R3 completion wins", 0, 2);
    peekChk("R4 unallocated", 50, 7);
    #1;
    chk("R5 retire head only", 64'(retValid), 8'b0000_0001);
    chk("R5 retIdx", 64'(retIdx[0]), 0);
    chk("R8 no write", 64'(stValid), 0);
    cyc();
    peekChk("R5 retired status", 0, 3);
    chk("R5 commitPtr", 64'(commitPtr), 1);
    aliasChk("R9 unrelated retire", 5, 1'b1, 2);
    cplValid = 2'b11; cplIdx[0] = 8'd0; cplIdx[1] = 8'd1;
    cyc();
    peekChk("R4 retired slot", 0, 3);
    cplValid = 2'b01; cplIdx[0] = 8'd2;
    #1;
    chk("R5 single", 64'(retValid), 8'b0000_0001);
    cyc();
    #1;
    chk("R5 last", 64'(retIdx[0]), 2);
    chk("R5 last valid", 64'(retValid), 8'b0000_0001);
    cyc();
    chk("R6 empty", 64'(robEmpty), 1);
    chk("R6 issuePtr", 64'(issuePtr), ROB_DEPTH);
    chk("R6 commitPtr", 64'(commitPtr), ROB_DEPTH);
    aliasChk("R9 cleared", 5, 1'b0, 0);
    allocValid = 8'b0000_0101;
    #1;
    chk("R2 gap lanes", 64'(allocGrant), 8'b0000_0001);
    chk("R2 restart idx", 64'(allocIdx[0]), 0);
    cyc();
    chk("R2 ptrs after gap", 64'({issuePtr, commitPtr}), 0);
  endtask

  task automatic testAliasYoung();
    doReset();
    allocValid = 8'b1; allocDstEn[0][0] = 1'b1; allocDstReg[0][0] = 6'd7;
    cyc();
    allocValid = 8'b1; allocDstEn[0][2] = 1'b1; allocDstReg[0][2] = 6'd7;
    cplValid = 2'b01; cplIdx[0] = 8'd0;
    cyc();
    #1;
    chk("R5 older retires", 64'(retValid), 8'b0000_0001);
    cyc();
    aliasChk("R9 younger kept", 7, 1'b1, 1);
  endtask

  task automatic testStore();
    doReset();
    allocValid = 8'b0000_0111;
    allocStAddr[0] = 32'h100; allocStSize[0] = 4'd4;
    allocStAddr[1] = 32'h200; allocStSize[1] = 4'd8;
    cyc();
    cplValid = 2'b11; cplIdx[0] = 8'd0; cplIdx[1] = 8'd1;
    cyc();
    cplValid = 2'b01; cplIdx[0] = 8'd2;
    cyc();
    lsqFree = 7'd1; #1;
    chk("R8 one slot", 64'(retValid), 8'b0000_0001);
    chk("R8 stValid", 64'(stValid), 8'b0000_0001);
    chk("R8 addr", 64'(stAddr[0]), 64'h100);
    chk("R8 size", 64'(stSize[0]), 4);
    cyc();
    #1;
    chk("R8 no room", 64'(retValid), 0);
    cyc();
    lsqFree = 7'd2; #1;
    chk("R8 two room", 64'(retValid), 8'b0000_0011);
    chk("R8 second write", 64'(stValid), 8'b0000_0001);
    chk("R8 addr2", 64'(stAddr[0]), 64'h200);
    chk("R8 size2", 64'(stSize[0]), 8);
    chk("R8 retIdx1", 64'(retIdx[1]), 2);
    cyc();
    chk("R6 store drain", 64'(robEmpty), 1);
  endtask

  task automatic testFull();
    doReset();
    for (int n = 0; n < ROB_DEPTH / ISSUE_W; n++) begin
      allocValid = '1;
      cyc();
    end
    chk("R7 full", 64'(robFull), 1);
    chk("R7 issuePtr", 64'(issuePtr), ROB_DEPTH - 1);
    chk("R7 commitPtr", 64'(commitPtr), 0);
    allocValid = '1; #1;
    chk("R7 blocked", 64'(allocGrant), 0);
    cyc();
    for (int p = 0; p < 5; p++) begin
      cplValid = 2'b11; cplIdx[0] = IDX_W'(1 + 2*p); cplIdx[1] = IDX_W'(2 + 2*p);
      cyc();
    end
    #1;
    chk("R5 hole blocks", 64'(retValid), 0);
    cplValid = 2'b01; cplIdx[0] = 8'd0;
    cyc();
    allocValid = '1; #1;
    chk("R5 eight wide", 64'(retValid), 8'hFF);
    chk("R5 lane7 idx", 64'(retIdx[7]), 7);
    chk("R7 freed next cycle", 64'(allocGrant), 0);
    cyc();
    chk("R5 commitPtr 8", 64'(commitPtr), 8);
    allocValid = '1; #1;
    chk("R5 tail three", 64'(retValid), 8'b0000_0111);
    chk("R2 wrap grant", 64'(allocGrant), 8'hFF);
    chk("R2 wrap idx0", 64'(allocIdx[0]), 0);
    chk("R2 wrap idx7", 64'(allocIdx[7]), 7);
    cyc();
    chk("R2 issuePtr wrapped", 64'(issuePtr), 7);
    chk("R7 not full", 64'(robFull), 0);
    allocValid = '1; #1;
    chk("R7 partial", 64'(allocGrant), 8'b0000_0111);
    chk("R7 partial idx", 64'(allocIdx[2]), 10);
    cyc();
    chk("R7 full again", 64'(robFull), 1);
  endtask

  initial begin
    testReset();
    testAllocStatus();
    testAliasYoung();
    testStore();
    testFull();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end
endmodule